// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block turns a stream of bus write cycles into the multi-cycle command sequences that a NOR-style parallel flash understands. Each write offers a word address and a command byte. The block tracks how far a sequence has advanced, which command it has latched, and whether unlock bypass is active. It then tells the read path which view a read should return: array data, identification, the query table, program status or erase status.

When a sequence is complete, the block issues a one-cycle request to the storage and erase blocks, and those carry out the work. Erase timing lives in a neighbouring block, which reports the end of an erase on `erase_done_i`. The block does not shift byte addresses into word addresses. That is done upstream: the byte address is shifted right by one for a 16-bit bus and by two for a 32-bit bus.

Top module: `nor_cmd_seq`

## Requirements
- R1: While `rst` is high and on the cycle after it falls, `mode_o` is 0 (array), `bypass_o` is 0 and all three request pulses are low.
- R2: An unlock is a write of 0xAA at unlock address A (default word 0x555), then 0x55 at unlock address B (default 0x2AA), then a command byte at A. Only word-address bits [10:0] take part in the compare. A wrong byte or address at any step returns the block to array mode.
- R3: Command 0xA0 enters program mode (`mode_o` = 3). The next write produces a one-cycle `prog_req_o` that carries the write's address and byte, and the block returns to array mode.
- R4: Command 0x90 enters autoselect mode (`mode_o` = 1). A write there other than the ones named in R9, R10 and R12 returns the block to array mode.
- R5: Command 0x80 needs a second unlock pair. The following write then starts an erase (`mode_o` = 4):
  - 0x10 at address A pulses `chip_erase_req_o`.
  - 0x30 at any address pulses `sect_erase_req_o` with that address on `erase_addr_o`.
  - 0x10 at any other address returns the block to array mode.
- R6: During a sector erase, each further 0x30 write pulses `sect_erase_req_o` again with its own address. All other writes are ignored. During a chip erase every write is ignored. At most one request pulse is high in any cycle.
- R7: While erasing, a high `erase_done_i` ends the erase. The block goes to array mode, or to the bypass command cycle if bypass is active.
- R8: 0x98 written at word 0x55 from array mode enters query mode (`mode_o` = 2). Any later write leaves query mode for array mode.
- R9: 0x98 written at word 0x55 from autoselect mode enters query mode, and a later 0xF0 there returns the block to autoselect.
- R10: 0xF0 returns the block to array mode and clears bypass. It has no effect while erasing. In program mode it is taken as the data byte.
- R11: Command 0x20 sets `bypass_o`. While bypass is active, a single write of a command byte at any address acts as the command cycle, and a completed program returns to that cycle.
- R12: In autoselect mode with bypass active, a write of 0x00 returns the block to array mode and clears bypass.
- R13: A command byte other than 0x20, 0x80, 0x90 or 0xA0 in the command cycle returns the block to array mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Write strobe, one cycle per bus write |
| wr_addr_i | input | ADDR_W | Word address of the write |
| wr_data_i | input | 8 | Command or program data byte |
| erase_done_i | input | 1 | Erase finished, from the erase timer |
| mode_o | output | 3 | Read view: 0 array, 1 autoselect, 2 query, 3 program, 4 erase |
| bypass_o | output | 1 | Unlock bypass active |
| prog_req_o | output | 1 | One-cycle program request |
| prog_addr_o | output | ADDR_W | Program target word address |
| prog_data_o | output | 8 | Program byte; storage applies old AND new |
| sect_erase_req_o | output | 1 | One-cycle sector erase request |
| chip_erase_req_o | output | 1 | One-cycle chip erase request |
| erase_addr_o | output | ADDR_W | Address within the sector to erase |

## Verification
Every output comes from a register, so all results of a write or of `erase_done_i` sampled at edge N are due just after edge N. This covers mode changes, the bypass flag and request pulses with their address and data. Each request pulse stays high for that one cycle only. The bench gives each scoreboard item a due cycle equal to the driving cycle plus one and compares it at the falling edge after that edge. An item therefore catches both a late pulse and a pulse that lingers into the following cycle. Ignored writes are confirmed by expecting an unchanged mode and no pulse in the cycle where a reaction would have appeared.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_UNL1,
        ST_CMD,
        ST_PROG,
        ST_AUTO,
        ST_EUNL0,
        ST_EUNL1,
        ST_ECMD,
        ST_CHIP,
        ST_SECT,
        ST_CFI,
        ST_CFI_AUTO
    } seq_state_e;

    typedef enum logic [2:0] {
        MODE_ARRAY   = 3'd0,
        MODE_AUTOSEL = 3'd1,
        MODE_QUERY   = 3'd2,
        MODE_PROG    = 3'd3,
        MODE_ERASE   = 3'd4
    } seq_mode_e;

    localparam int unsigned CMP_W = 11;

    localparam logic [7:0] CMD_UNLK1   = 8'hAA;
    localparam logic [7:0] CMD_UNLK2   = 8'h55;
    localparam logic [7:0] CMD_BYPASS  = 8'h20;
    localparam logic [7:0] CMD_ERASE   = 8'h80;
    localparam logic [7:0] CMD_AUTOSEL = 8'h90;
    localparam logic [7:0] CMD_PROGRAM = 8'hA0;
    localparam logic [7:0] CMD_CHIP    = 8'h10;
    localparam logic [7:0] CMD_SECTOR  = 8'h30;
    localparam logic [7:0] CMD_QUERY   = 8'h98;
    localparam logic [7:0] CMD_RESET   = 8'hF0;
    localparam logic [7:0] CMD_BYP_OUT = 8'h00;

endpackage

// File: rtl/nor_addr_match.sv
module nor_addr_match
    import nor_seq_pkg::*;
#(
    parameter logic [CMP_W-1:0] UNLOCK_A = 11'h555,
    parameter logic [CMP_W-1:0] UNLOCK_B = 11'h2AA,
    parameter logic [CMP_W-1:0] QUERY_AT = 11'h055
) (
    input  logic [CMP_W-1:0] low_addr_i,
    output logic             hit_a_o,
    output logic             hit_b_o,
    output logic             hit_query_o
);
    assign hit_a_o     = (low_addr_i == UNLOCK_A);
    assign hit_b_o     = (low_addr_i == UNLOCK_B);
    assign hit_query_o = (low_addr_i == QUERY_AT);
endmodule

// File: rtl/nor_seq_fsm.sv
module nor_seq_fsm
    import nor_seq_pkg::*;
#(
    parameter int unsigned ADDR_W = 22
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [7:0]        wr_data_i,
    input  logic              erase_done_i,
    input  logic              hit_a_i,
    input  logic              hit_b_i,
    input  logic              hit_query_i,
    output logic [2:0]        mode_o,
    output logic              bypass_o,
    output logic              prog_req_o,
    output logic              sect_req_o,
    output logic              chip_req_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [7:0]        data_o
);
    typedef struct packed {
        seq_state_e        st;
        logic              byp;
        logic              prog;
        logic              sect;
        logic              chip;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
    } seq_regs_t;

    seq_regs_t seq_d, seq_q;
    logic      drop;
    logic      erasing;

    assign erasing = (seq_q.st == ST_CHIP) || (seq_q.st == ST_SECT);

    always_comb begin
        seq_d      = seq_q;
        seq_d.prog = 1'b0;
        seq_d.sect = 1'b0;
        seq_d.chip = 1'b0;
        drop       = 1'b0;
        if (erasing && erase_done_i) begin
            seq_d.st = seq_q.byp ? ST_CMD : ST_IDLE;
        end else if (wr_en_i) begin
            if (wr_data_i == CMD_RESET && seq_q.st != ST_PROG && !erasing) begin
                if (seq_q.st == ST_CFI_AUTO) seq_d.st = ST_AUTO;
                else                         drop = 1'b1;
            end else begin
                case (seq_q.st)
                    ST_IDLE, ST_EUNL0: begin
                        if (hit_query_i && wr_data_i == CMD_QUERY)
                            seq_d.st = ST_CFI;
                        else if (hit_a_i && wr_data_i == CMD_UNLK1)
                            seq_d.st = (seq_q.st == ST_IDLE) ? ST_UNL1 : ST_EUNL1;
                        else
                            drop = 1'b1;
                    end
                    ST_UNL1, ST_EUNL1: begin
                        if (hit_b_i && wr_data_i == CMD_UNLK2)
                            seq_d.st = (seq_q.st == ST_UNL1) ? ST_CMD : ST_ECMD;
                        else
                            drop = 1'b1;
                    end
                    ST_CMD: begin
                        if (!seq_q.byp && !hit_a_i) begin
                            drop = 1'b1;
                        end else begin
                            case (wr_data_i)
                                CMD_BYPASS:  seq_d.byp = 1'b1;
                                CMD_ERASE:   seq_d.st  = ST_EUNL0;
                                CMD_AUTOSEL: seq_d.st  = ST_AUTO;
                                CMD_PROGRAM: seq_d.st  = ST_PROG;
                                default:     drop      = 1'b1;
                            endcase
                        end
                    end
                    ST_PROG: begin
                        seq_d.prog = 1'b1;
                        seq_d.addr = wr_addr_i;
                        seq_d.data = wr_data_i;
                        seq_d.st   = seq_q.byp ? ST_CMD : ST_IDLE;
                    end
                    ST_AUTO: begin
                        if (seq_q.byp && wr_data_i == CMD_BYP_OUT)
                            drop = 1'b1;
                        else if (hit_query_i && wr_data_i == CMD_QUERY)
                            seq_d.st = ST_CFI_AUTO;
                        else
                            drop = 1'b1;
                    end
                    ST_ECMD: begin
                        if (wr_data_i == CMD_CHIP && hit_a_i) begin
                            seq_d.chip = 1'b1;
                            seq_d.st   = ST_CHIP;
                        end else if (wr_data_i == CMD_SECTOR) begin
                            seq_d.sect = 1'b1;
                            seq_d.addr = wr_addr_i;
                            seq_d.st   = ST_SECT;
                        end else begin
                            drop = 1'b1;
                        end
                    end
                    ST_CHIP: ;
                    ST_SECT: begin
                        if (wr_data_i == CMD_SECTOR) begin
                            seq_d.sect = 1'b1;
                            seq_d.addr = wr_addr_i;
                        end
                    end
                    default: drop = 1'b1;
                endcase
            end
        end
        if (drop) begin
            seq_d.st  = ST_IDLE;
            seq_d.byp = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q.st   <= ST_IDLE;
            seq_q.byp  <= 1'b0;
            seq_q.prog <= 1'b0;
            seq_q.sect <= 1'b0;
            seq_q.chip <= 1'b0;
            seq_q.addr <= '0;
            seq_q.data <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    always_comb begin
        case (seq_q.st)
            ST_AUTO:             mode_o = MODE_AUTOSEL;
            ST_CFI, ST_CFI_AUTO: mode_o = MODE_QUERY;
            ST_PROG:             mode_o = MODE_PROG;
            ST_CHIP, ST_SECT:    mode_o = MODE_ERASE;
            default:             mode_o = MODE_ARRAY;
        endcase
    end

    assign bypass_o   = seq_q.byp;
    assign prog_req_o = seq_q.prog;
    assign sect_req_o = seq_q.sect;
    assign chip_req_o = seq_q.chip;
    assign addr_o     = seq_q.addr;
    assign data_o     = seq_q.data;
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
    import nor_seq_pkg::*;
#(
    parameter int unsigned      ADDR_W   = 22,
    parameter logic [CMP_W-1:0] UNLOCK_A = 11'h555,
    parameter logic [CMP_W-1:0] UNLOCK_B = 11'h2AA
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [7:0]        wr_data_i,
    input  logic              erase_done_i,
    output logic [2:0]        mode_o,
    output logic              bypass_o,
    output logic              prog_req_o,
    output logic [ADDR_W-1:0] prog_addr_o,
    output logic [7:0]        prog_data_o,
    output logic              sect_erase_req_o,
    output logic              chip_erase_req_o,
    output logic [ADDR_W-1:0] erase_addr_o
);
    localparam logic [CMP_W-1:0] QUERY_AT = 11'h055;

    logic [CMP_W-1:0]  low_addr;
    logic              hit_a, hit_b, hit_query;
    logic [ADDR_W-1:0] req_addr;

    generate
        if (ADDR_W >= CMP_W) begin : g_slice
            assign low_addr = wr_addr_i[CMP_W-1:0];
        end else begin : g_pad
            assign low_addr = {{(CMP_W-ADDR_W){1'b0}}, wr_addr_i};
        end
    endgenerate

    nor_addr_match #(
        .UNLOCK_A (UNLOCK_A),
        .UNLOCK_B (UNLOCK_B),
        .QUERY_AT (QUERY_AT)
    ) match_i (
        .low_addr_i  (low_addr),
        .hit_a_o     (hit_a),
        .hit_b_o     (hit_b),
        .hit_query_o (hit_query)
    );

    nor_seq_fsm #(
        .ADDR_W (ADDR_W)
    ) fsm_i (
        .clk          (clk),
        .rst          (rst),
        .wr_en_i      (wr_en_i),
        .wr_addr_i    (wr_addr_i),
        .wr_data_i    (wr_data_i),
        .erase_done_i (erase_done_i),
        .hit_a_i      (hit_a),
        .hit_b_i      (hit_b),
        .hit_query_i  (hit_query),
        .mode_o       (mode_o),
        .bypass_o     (bypass_o),
        .prog_req_o   (prog_req_o),
        .sect_req_o   (sect_erase_req_o),
        .chip_req_o   (chip_erase_req_o),
        .addr_o       (req_addr),
        .data_o       (prog_data_o)
    );

    assign prog_addr_o  = req_addr;
    assign erase_addr_o = req_addr;
endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en_i,
    input logic [7:0] wr_data_i,
    input logic       erase_done_i,
    input logic [2:0] mode_o,
    input logic       bypass_o,
    input logic       prog_req_o,
    input logic       sect_erase_req_o,
    input logic       chip_erase_req_o
);
    // R6
    pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({prog_req_o, sect_erase_req_o, chip_erase_req_o}));

    // R3
    prog_origin_chk: assert property (@(posedge clk) disable iff (rst)
        prog_req_o |-> $past(mode_o) == 3'd3);

    // R5
    chip_mode_chk: assert property (@(posedge clk) disable iff (rst)
        chip_erase_req_o |-> mode_o == 3'd4);

    // R10
    erase_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 3'd4 && wr_en_i && wr_data_i == 8'hF0 && !erase_done_i)
        |=> mode_o == 3'd4);

    // R8
    query_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 3'd2 && wr_en_i && wr_data_i != 8'hF0)
        |=> (mode_o == 3'd0 && !bypass_o));

    // R7
    done_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 3'd4 && erase_done_i) |=> mode_o != 3'd4);
endmodule

bind nor_cmd_seq nor_cmd_seq_chk chk_i (
    .clk              (clk),
    .rst              (rst),
    .wr_en_i          (wr_en_i),
    .wr_data_i        (wr_data_i),
    .erase_done_i     (erase_done_i),
    .mode_o           (mode_o),
    .bypass_o         (bypass_o),
    .prog_req_o       (prog_req_o),
    .sect_erase_req_o (sect_erase_req_o),
    .chip_erase_req_o (chip_erase_req_o)
);

// File: tb/nor_cmd_seq_tb_top.sv
`timescale 1ns/1ps
module nor_cmd_seq_tb_top;
    localparam int AW = 22;
    localparam logic [AW-1:0] UA = 22'h555;
    localparam logic [AW-1:0] UB = 22'h2AA;
    localparam logic [AW-1:0] UQ = 22'h055;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic          done = 1'b0;
    logic [2:0]    mode;
    logic          byp, preq, sreq, creq;
    logic [AW-1:0] paddr, eaddr;
    logic [7:0]    pdata;

    int cyc = 0;
    int vectors = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        int            due;
        logic [2:0]    m;
        logic          b, p, s, c;
        logic [AW-1:0] a;
        logic [7:0]    d;
        string         tag;
    } exp_t;
    exp_t exp_q[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    nor_cmd_seq #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .erase_done_i(done), .mode_o(mode),
        .bypass_o(byp), .prog_req_o(preq), .prog_addr_o(paddr),
        .prog_data_o(pdata), .sect_erase_req_o(sreq),
        .chip_erase_req_o(creq), .erase_addr_o(eaddr)
    );

    // monitor: compare each item once its due edge has passed
    always @(negedge clk) begin
        while (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
            exp_t e;
            bit bad;
            e = exp_q.pop_front();
            vectors++;
            bad = (mode !== e.m) || (byp !== e.b) || (preq !== e.p) ||
                  (sreq !== e.s) || (creq !== e.c) ||
                  (e.p && (paddr !== e.a || pdata !== e.d)) ||
                  (e.s && eaddr !== e.a);
            if (bad) begin
                errors++;
                $display("FAIL %s: got mode=%0d byp=%0b p=%0b s=%0b c=%0b paddr=%h pdata=%h eaddr=%h exp mode=%0d byp=%0b p=%0b s=%0b c=%0b addr=%h data=%h",
                         e.tag, mode, byp, preq, sreq, creq, paddr, pdata, eaddr,
                         e.m, e.b, e.p, e.s, e.c, e.a, e.d);
            end
        end
    end

    task automatic step(input logic w, input logic [AW-1:0] a, input logic [7:0] d,
                        input logic dn, input logic [2:0] m, input logic b,
                        input logic p, input logic s, input logic c, input string tag);
        exp_t e;
        @(posedge clk); #1;
        wr_en = w; wr_addr = a; wr_data = d; done = dn;
        e.due = cyc + 1; e.m = m; e.b = b; e.p = p; e.s = s; e.c = c;
        e.a = a; e.d = d; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d,
                      input logic [2:0] m, input logic b, input string tag);
        step(1'b1, a, d, 1'b0, m, b, 1'b0, 1'b0, 1'b0, tag);
    endtask

    task automatic unlock(input logic b, input string tag);
        wr(UA, 8'hAA, 3'd0, b, tag);
        wr(UB, 8'h55, 3'd0, b, tag);
    endtask

    task automatic idle(input logic [2:0] m, input logic b, input string tag);
        step(1'b0, '0, 8'h00, 1'b0, m, b, 1'b0, 1'b0, 1'b0, tag);
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            errors++;
            vectors++;
            $display("FAIL watchdog: got hung run, exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        exp_t r;
        repeat (3) @(posedge clk);
        #1;
        r.due = cyc; r.m = 3'd0; r.b = 1'b0; r.p = 1'b0; r.s = 1'b0; r.c = 1'b0;
        r.a = '0; r.d = '0; r.tag = "R1 in reset";
        exp_q.push_back(r);
        @(posedge clk); #1;
        rst = 1'b0;
        idle(3'd0, 1'b0, "R1 after reset");

        // R3 program
        unlock(1'b0, "R2 unlock");
        wr(UA, 8'hA0, 3'd3, 1'b0, "R3 enter program");
        step(1'b1, 22'h0091A, 8'h3C, 1'b0, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0, "R3 program pulse");
        idle(3'd0, 1'b0, "R3 pulse one cycle");

        // R2 mismatch at second cycle
        wr(UA, 8'hAA, 3'd0, 1'b0, "R2 first");
        wr(22'h2AB, 8'h55, 3'd0, 1'b0, "R2 bad addr");
        wr(UA, 8'hA0, 3'd0, 1'b0, "R2 no command after mismatch");
        wr(22'h00100, 8'h11, 3'd0, 1'b0, "R2 no program after mismatch");

        // R2 upper bits ignored, R4 autoselect, R9 query from autoselect
        wr(UA | 22'h8000, 8'hAA, 3'd0, 1'b0, "R2 alias a");
        wr(UB | 22'h0800, 8'h55, 3'd0, 1'b0, "R2 alias b");
        wr(UA | 22'h10000, 8'h90, 3'd1, 1'b0, "R4 autoselect");
        wr(UQ, 8'h98, 3'd2, 1'b0, "R9 query from autoselect");
        wr(22'h0, 8'hF0, 3'd1, 1'b0, "R9 back to autoselect");
        wr(22'h0, 8'h00, 3'd0, 1'b0, "R4 other write leaves autoselect");

        // R8 query from array
        wr(UQ, 8'h98, 3'd2, 1'b0, "R8 enter query");
        wr(22'h0, 8'h12, 3'd0, 1'b0, "R8 write leaves query");

        // R5 chip erase, R6 ignored writes, R7 done
        unlock(1'b0, "R5 unlock");
        wr(UA, 8'h80, 3'd0, 1'b0, "R5 erase cmd");
        unlock(1'b0, "R5 second unlock");
        step(1'b1, UA, 8'h10, 1'b0, 3'd4, 1'b0, 1'b0, 1'b0, 1'b1, "R5 chip pulse");
        wr(22'h0, 8'hF0, 3'd4, 1'b0, "R10 reset ignored in chip erase");
        wr(22'h40, 8'h30, 3'd4, 1'b0, "R6 chip erase ignores writes");
        step(1'b0, '0, 8'h0, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, "R7 chip done");

        // R5 sector erase and R6 additional sectors
        unlock(1'b0, "R5 unlock");
        wr(UA, 8'h80, 3'd0, 1'b0, "R5 erase cmd");
        unlock(1'b0, "R5 second unlock");
        step(1'b1, 22'h04000, 8'h30, 1'b0, 3'd4, 1'b0, 1'b0, 1'b1, 1'b0, "R5 sector pulse");
        step(1'b1, 22'h10000, 8'h30, 1'b0, 3'd4, 1'b0, 1'b0, 1'b1, 1'b0, "R6 extra sector");
        wr(22'h0, 8'hF0, 3'd4, 1'b0, "R10 reset ignored in sector erase");
        wr(22'h0, 8'h55, 3'd4, 1'b0, "R6 other write ignored");
        step(1'b0, '0, 8'h0, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, "R7 sector done");

        // R5 chip command at wrong address
        unlock(1'b0, "R5 unlock");
        wr(UA, 8'h80, 3'd0, 1'b0, "R5 erase cmd");
        unlock(1'b0, "R5 second unlock");
        wr(22'h123, 8'h10, 3'd0, 1'b0, "R5 chip at wrong address");

        // R11 bypass
        unlock(1'b0, "R11 unlock");
        wr(UA, 8'h20, 3'd0, 1'b1, "R11 bypass on");
        wr(22'h300, 8'hA0, 3'd3, 1'b1, "R11 program any address");
        step(1'b1, 22'h200, 8'h5A, 1'b0, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0, "R11 bypass program");
        wr(22'h010, 8'hA0, 3'd3, 1'b1, "R11 back at command cycle");
        step(1'b1, 22'h201, 8'hF0, 1'b0, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0, "R10 F0 as program data");

        // R12 bypass exit through autoselect
        wr(22'h0, 8'h90, 3'd1, 1'b1, "R12 bypass autoselect");
        wr(22'h0, 8'h00, 3'd0, 1'b0, "R12 bypass exit");
        wr(22'h300, 8'hA0, 3'd0, 1'b0, "R12 no bypass command after exit");

        // R10 reset clears bypass
        unlock(1'b0, "R10 unlock");
        wr(UA, 8'h20, 3'd0, 1'b1, "R11 bypass on");
        wr(22'h0, 8'hF0, 3'd0, 1'b0, "R10 reset clears bypass");
        wr(22'h300, 8'hA0, 3'd0, 1'b0, "R10 no bypass after reset");

        // R13 unknown command
        unlock(1'b0, "R13 unlock");
        wr(UA, 8'h44, 3'd0, 1'b0, "R13 unknown command");
        wr(22'h100, 8'h00, 3'd0, 1'b0, "R13 sequence restarted");

        // R7 bypass erase returns to command cycle
        unlock(1'b0, "R7 unlock");
        wr(UA, 8'h20, 3'd0, 1'b1, "R11 bypass on");
        wr(22'h7, 8'h80, 3'd0, 1'b1, "R7 bypass erase cmd");
        unlock(1'b1, "R7 second unlock");
        step(1'b1, 22'h08000, 8'h30, 1'b0, 3'd4, 1'b1, 1'b0, 1'b1, 1'b0, "R7 bypass sector");
        step(1'b0, '0, 8'h0, 1'b1, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, "R7 done in bypass");
        wr(22'h9, 8'hA0, 3'd3, 1'b1, "R7 at bypass command cycle");
        step(1'b1, 22'h00042, 8'h81, 1'b0, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0, "R11 program after erase");

        idle(3'd0, 1'b1, "R11 idle");
        @(posedge clk); #1;
        wr_en = 1'b0; done = 1'b0;
        repeat (3) @(posedge clk);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule